// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits on the receive side of an Ethernet MAC. It decides whether a frame is kept by looking only at the frame's 48-bit destination address. The first six bytes of a frame arrive on a byte-wide receive port, and the first of them is marked as start of frame. While those bytes arrive, the block builds the address and a running CRC-32. It then scans a table of programmed addresses once and gives a single-cycle decision. The decision says whether the frame is accepted and which kind of match was found.

The table has two layouts. In exact mode all 64 slots hold addresses to compare against. In hash mode, slots 0 to 61 still hold addresses, and the space of the last two slots holds a 64-bit hash mask instead. Six bits of the CRC pick one bit of that mask. Any address may be programmed as an exact entry or through the mask, whatever its type.

A host programs the table through a simple request/acknowledge memory port. The port acknowledges only the locations that exist in the current layout. The table contents are not reset, so software clears every slot before it enables filtering. The layout a frame uses is the one selected when its first byte arrives.

Top module: `dest_addr_filter`

## Requirements
- R1: A host request to a legal location is acknowledged by `host_ack` high in the cycle after the request. A write stores the 49-bit word, and a read returns in `host_rdata`, in the same acknowledged cycle, the word last written to that location.
- R2: The following requests get no acknowledge:
  - any address of 66 or above;
  - in exact mode, addresses 64 and 65;
  - in hash mode, addresses 62 and 63.
- R3: In exact mode all 64 slots (0 to 63) are compared. Each slot holds the valid flag in bit 48 and the address in bits 47:0, with the first received byte in bits 47:40. A frame whose address equals a valid slot gives accept = 1 with match code 1 (exact). This includes slot 63.
- R4: A slot whose bit 48 is 0 never produces a match, even when its address bits equal the frame's destination address.
- R5: The CRC starts at all ones. Each byte is fed least-significant bit first into a left-shifting register with polynomial 0x04C11DB7. After the sixth byte, bits 31:26 of the register form a 6-bit index. In hash mode, a frame whose indexed mask bit is 1 and that has no exact match gives accept = 1 with match code 2 (hash).
- R6: In hash mode the hash mask is handled as follows:
  - host address 64 holds mask bits 31:0 in data bits 31:0, stored in slot 62;
  - host address 65 holds mask bits 63:32, stored in slot 63;
  - only slots 0 to 61 take part in the address compare.
- R7: A frame that matches a valid exact entry and also hits a set mask bit is reported with match code 1 (exact).
- R8: A frame with no exact match and no mask hit gives accept = 0 with match code 0 (none). `dec_accept` is 1 exactly when the match code is not 0.
- R9: The decision strobe `dec_valid` is high for one cycle only. It rises after the 66th clock edge that follows the edge taking the sixth address byte. Bytes received after the sixth do not change the decision.
- R10: The table layout used for a frame is the value of `cfg_hash_mode` sampled with its start-of-frame byte. A change later in the same frame does not affect that frame's decision.
- R11: Reset drives `dec_valid`, `dec_accept` and `host_ack` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_hash_mode | input | 1 | 0 = 64 exact entries, 1 = 62 exact entries plus hash mask |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Host word address (0-63 slots, 64/65 mask halves) |
| host_wdata | input | 49 | Host write data |
| host_rdata | output | 49 | Host read data, valid with host_ack |
| host_ack | output | 1 | Access acknowledge |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Receive byte |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_match | output | 2 | 0 none, 1 exact, 2 hash |

## Verification
The host port and the address scan both read the table storage, and they can read it in the same cycle. The bench holds a host read request on a programmed slot during the whole scan of a hash-mode frame. On every probed cycle it expects the acknowledge and the stored word. When the scan ends, it expects the decision worked out from the mask, so that neither reader disturbs the other. A second overlap covers a mode change inside a frame: the frame must be judged by the layout sampled at its first byte.

// File: rtl/daf_pkg.sv
package daf_pkg;
  typedef enum logic [1:0] {
    MT_NONE  = 2'd0,
    MT_EXACT = 2'd1,
    MT_HASH  = 2'd2
  } match_t;

  localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
endpackage

// File: rtl/daf_crc_byte.sv
module daf_crc_byte
  import daf_pkg::*;
(
  input  logic [31:0] crc_in,
  input  logic [7:0]  data,
  output logic [31:0] crc_out
);
  always_comb begin
    logic [31:0] c;
    c = crc_in;
    for (int k = 0; k < 8; k++) begin
      if (c[31] ^ data[k]) c = {c[30:0], 1'b0} ^ CRC_POLY;
      else                 c = {c[30:0], 1'b0};
    end
    crc_out = c;
  end
endmodule

// File: rtl/daf_capture.sv
module daf_capture #(
  parameter int DA_BYTES  = 6,
  parameter int HASH_BITS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_hash_mode,
  input  logic                    rx_valid,
  input  logic                    rx_sof,
  input  logic [7:0]              rx_data,
  output logic [8*DA_BYTES-1:0]   da,
  output logic [HASH_BITS-1:0]    hash_idx,
  output logic                    frame_hash_mode,
  output logic                    da_done
);
  localparam int DA_W  = 8 * DA_BYTES;
  localparam int CNT_W = $clog2(DA_BYTES + 1);

  logic [CNT_W-1:0] cnt;
  logic [31:0]      crc, crc_seed, crc_next;
  logic             take;

  assign crc_seed = rx_sof ? '1 : crc;
  assign take     = rx_valid && (rx_sof || cnt < CNT_W'(DA_BYTES));
  assign hash_idx = crc[31 -: HASH_BITS];

  daf_crc_byte u_crc (.crc_in(crc_seed), .data(rx_data), .crc_out(crc_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt             <= '0;
      crc             <= '1;
      da              <= '0;
      frame_hash_mode <= 1'b0;
      da_done         <= 1'b0;
    end else begin
      da_done <= 1'b0;
      if (take) begin
        da  <= {da[DA_W-9:0], rx_data};
        crc <= crc_next;
        if (rx_sof) begin
          cnt             <= CNT_W'(1);
          frame_hash_mode <= cfg_hash_mode;
          da_done         <= (DA_BYTES == 1);
        end else begin
          cnt     <= cnt + CNT_W'(1);
          da_done <= (cnt == CNT_W'(DA_BYTES - 1));
        end
      end
    end
  end
endmodule

// File: rtl/daf_table.sv
module daf_table #(
  parameter int DEPTH = 64,
  parameter int W     = 49,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [W-1:0]  a_wdata,
  output logic [W-1:0]  a_rdata,
  input  logic [AW-1:0] b_addr,
  output logic [W-1:0]  b_rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_en) begin
      if (a_we) mem[a_addr] <= a_wdata;
      a_rdata <= mem[a_addr];
    end
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/daf_host.sv
module daf_host #(
  parameter int N_SLOTS = 64,
  parameter int SLOT_AW = $clog2(N_SLOTS),
  parameter int HA_W    = SLOT_AW + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hash_mode,
  input  logic               req,
  input  logic               we,
  input  logic [HA_W-1:0]    addr,
  output logic               mem_en,
  output logic               mem_we,
  output logic [SLOT_AW-1:0] mem_addr,
  output logic               ack
);
  logic in_slots, in_mask, legal;

  always_comb begin
    in_slots = addr < HA_W'(N_SLOTS);
    in_mask  = (addr == HA_W'(N_SLOTS)) || (addr == HA_W'(N_SLOTS + 1));
    if (hash_mode) legal = (in_slots && addr < HA_W'(N_SLOTS - 2)) || in_mask;
    else           legal = in_slots;
    mem_addr = in_mask ? SLOT_AW'(N_SLOTS - 2) + SLOT_AW'(addr[0])
                       : addr[SLOT_AW-1:0];
    mem_en   = req && legal;
    mem_we   = mem_en && we;
  end

  always_ff @(posedge clk) begin
    if (rst) ack <= 1'b0;
    else     ack <= mem_en;
  end
endmodule

// File: rtl/daf_scan.sv
module daf_scan
  import daf_pkg::*;
#(
  parameter int N_SLOTS   = 64,
  parameter int DA_W      = 48,
  parameter int HASH_BITS = 6,
  parameter int SLOT_AW   = $clog2(N_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DA_W-1:0]      da,
  input  logic [HASH_BITS-1:0] hash_idx,
  input  logic                 hash_mode,
  output logic [SLOT_AW-1:0]   rd_addr,
  input  logic [DA_W:0]        rd_data,
  output logic                 dec_valid,
  output logic                 dec_accept,
  output match_t               dec_match
);
  localparam int HALF = (2 ** HASH_BITS) / 2;

  logic                 busy, issuing, p_vld;
  logic [SLOT_AW-1:0]   p_idx;
  logic [DA_W-1:0]      snap_da;
  logic [HASH_BITS-1:0] snap_idx;
  logic                 snap_mode;
  logic [HALF-1:0]      mask_lo;
  logic                 exact_acc;
  logic                 slot_is_entry, hit, hash_bit, last;

  always_comb begin
    slot_is_entry = !snap_mode || (p_idx < SLOT_AW'(N_SLOTS - 2));
    hit      = p_vld && slot_is_entry && rd_data[DA_W] && (rd_data[DA_W-1:0] == snap_da);
    hash_bit = snap_idx[HASH_BITS-1] ? rd_data[snap_idx[HASH_BITS-2:0]]
                                     : mask_lo[snap_idx[HASH_BITS-2:0]];
    last     = p_vld && (p_idx == SLOT_AW'(N_SLOTS - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      issuing    <= 1'b0;
      rd_addr    <= '0;
      p_vld      <= 1'b0;
      p_idx      <= '0;
      snap_da    <= '0;
      snap_idx   <= '0;
      snap_mode  <= 1'b0;
      mask_lo    <= '0;
      exact_acc  <= 1'b0;
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_match  <= MT_NONE;
    end else begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_match  <= MT_NONE;
      p_vld      <= issuing;
      p_idx      <= rd_addr;
      if (start && !busy) begin
        busy      <= 1'b1;
        issuing   <= 1'b1;
        rd_addr   <= '0;
        snap_da   <= da;
        snap_idx  <= hash_idx;
        snap_mode <= hash_mode;
        exact_acc <= 1'b0;
      end else if (issuing) begin
        rd_addr <= rd_addr + SLOT_AW'(1);
        if (rd_addr == SLOT_AW'(N_SLOTS - 1)) issuing <= 1'b0;
      end
      if (p_vld) begin
        exact_acc <= exact_acc || hit;
        if (snap_mode && p_idx == SLOT_AW'(N_SLOTS - 2)) mask_lo <= rd_data[HALF-1:0];
      end
      if (last) begin
        busy      <= 1'b0;
        dec_valid <= 1'b1;
        if (exact_acc || hit) begin
          dec_accept <= 1'b1;
          dec_match  <= MT_EXACT;
        end else if (snap_mode && hash_bit) begin
          dec_accept <= 1'b1;
          dec_match  <= MT_HASH;
        end
      end
    end
  end
endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import daf_pkg::*;
#(
  parameter int N_SLOTS   = 64,
  parameter int DA_BYTES  = 6,
  parameter int HASH_BITS = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_hash_mode,
  input  logic                      host_req,
  input  logic                      host_we,
  input  logic [$clog2(N_SLOTS):0]  host_addr,
  input  logic [8*DA_BYTES:0]       host_wdata,
  output logic [8*DA_BYTES:0]       host_rdata,
  output logic                      host_ack,
  input  logic                      rx_valid,
  input  logic                      rx_sof,
  input  logic [7:0]                rx_data,
  output logic                      dec_valid,
  output logic                      dec_accept,
  output logic [1:0]                dec_match
);
  localparam int DA_W    = 8 * DA_BYTES;
  localparam int ENTRY_W = DA_W + 1;
  localparam int SLOT_AW = $clog2(N_SLOTS);
  localparam int HA_W    = SLOT_AW + 1;

  logic                 mem_en, mem_we;
  logic [SLOT_AW-1:0]   mem_addr, scan_addr;
  logic [ENTRY_W-1:0]   scan_data;
  logic [DA_W-1:0]      cap_da;
  logic [HASH_BITS-1:0] cap_idx;
  logic                 cap_mode, cap_done;
  match_t               match_q;

  daf_host #(.N_SLOTS(N_SLOTS), .SLOT_AW(SLOT_AW), .HA_W(HA_W)) u_host (
    .clk(clk), .rst(rst), .hash_mode(cfg_hash_mode),
    .req(host_req), .we(host_we), .addr(host_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .ack(host_ack)
  );

  daf_table #(.DEPTH(N_SLOTS), .W(ENTRY_W), .AW(SLOT_AW)) u_table (
    .clk(clk),
    .a_en(mem_en), .a_we(mem_we), .a_addr(mem_addr),
    .a_wdata(host_wdata), .a_rdata(host_rdata),
    .b_addr(scan_addr), .b_rdata(scan_data)
  );

  daf_capture #(.DA_BYTES(DA_BYTES), .HASH_BITS(HASH_BITS)) u_capture (
    .clk(clk), .rst(rst), .cfg_hash_mode(cfg_hash_mode),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .da(cap_da), .hash_idx(cap_idx), .frame_hash_mode(cap_mode), .da_done(cap_done)
  );

  daf_scan #(.N_SLOTS(N_SLOTS), .DA_W(DA_W), .HASH_BITS(HASH_BITS), .SLOT_AW(SLOT_AW)) u_scan (
    .clk(clk), .rst(rst), .start(cap_done),
    .da(cap_da), .hash_idx(cap_idx), .hash_mode(cap_mode),
    .rd_addr(scan_addr), .rd_data(scan_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(match_q)
  );

  assign dec_match = match_q;
endmodule

// File: rtl/daf_checker.sv
module daf_checker #(
  parameter int N_SLOTS = 64
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     cfg_hash_mode,
  input logic                     host_req,
  input logic [$clog2(N_SLOTS):0] host_addr,
  input logic                     host_ack,
  input logic                     dec_valid,
  input logic                     dec_accept,
  input logic [1:0]               dec_match
);
  localparam int HA_W = $clog2(N_SLOTS) + 1;

  a_r1_ack_needs_req: assert property (@(posedge clk) disable iff (rst)
    host_ack |-> $past(host_req));

  a_r2_no_ack_beyond: assert property (@(posedge clk) disable iff (rst)
    (host_req && host_addr >= HA_W'(N_SLOTS + 2)) |=> !host_ack);

  a_r2_no_mask_in_exact: assert property (@(posedge clk) disable iff (rst)
    (host_req && !cfg_hash_mode && host_addr >= HA_W'(N_SLOTS)) |=> !host_ack);

  a_r2_no_top_slots_in_hash: assert property (@(posedge clk) disable iff (rst)
    (host_req && cfg_hash_mode && (host_addr == HA_W'(N_SLOTS - 2) ||
                                   host_addr == HA_W'(N_SLOTS - 1))) |=> !host_ack);

  a_r9_single_strobe: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  a_r8_accept_follows_code: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> ((dec_accept == (dec_match != 2'd0)) && dec_match != 2'd3));

  a_r11_quiet_between: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !dec_accept);
endmodule

bind dest_addr_filter daf_checker #(.N_SLOTS(N_SLOTS)) u_daf_checker (
  .clk(clk), .rst(rst), .cfg_hash_mode(cfg_hash_mode),
  .host_req(host_req), .host_addr(host_addr), .host_ack(host_ack),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(dec_match)
);

// File: tb/test_dest_addr_filter.sv
`timescale 1ns/1ps
module test_dest_addr_filter;
  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_hash_mode = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [48:0] host_wdata = '0;
  logic [48:0] host_rdata;
  logic        host_ack;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_match;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dest_addr_filter i_dest_addr_filter (
    .clk(clk), .rst(rst), .cfg_hash_mode(cfg_hash_mode),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ack(host_ack),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(dec_match)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] hidx(input logic [47:0] da);
    logic [31:0] c = '1;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] byt = da[47 - 8*b -: 8];
      for (int k = 0; k < 8; k++) begin
        logic fb = c[31] ^ byt[k];
        c = {c[30:0], 1'b0};
        if (fb) c = c ^ 32'h04C11DB7;
      end
    end
    return c[31:26];
  endfunction

  task automatic host_op(input bit we, input logic [6:0] a, input logic [48:0] d,
                         output bit ackd, output logic [48:0] rd);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_wdata = d;
    @(negedge clk);
    ackd = host_ack; rd = host_rdata;
    host_req = 1'b0; host_we = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [48:0] d);
    bit ak; logic [48:0] rd;
    host_op(1'b1, a, d, ak, rd);
  endtask

  // Sends a destination address; optional extra junk bytes, mid-frame mode flip,
  // and a host read probe of slot 0 held through the scan.
  task automatic frame(input logic [47:0] da, input int extra, input bit flip,
                       input bit probe, input logic [48:0] probe_exp,
                       output int lat, output bit acc, output logic [1:0] mt);
    for (int b = 0; b < 6; b++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_sof = (b == 0); rx_data = da[47 - 8*b -: 8];
      if (flip && b == 2) cfg_hash_mode = ~cfg_hash_mode;
    end
    @(negedge clk);
    rx_sof = 1'b0; rx_valid = (extra > 0); rx_data = 8'hA5;
    if (probe) begin host_req = 1'b1; host_we = 1'b0; host_addr = 7'd0; end
    lat = 0;
    while (!dec_valid && lat < 300) begin
      @(negedge clk);
      lat++;
      rx_valid = (lat < extra); rx_data = 8'h5A ^ 8'(lat);
      if (probe && lat >= 2 && lat <= 60)
        chk(host_ack && host_rdata == probe_exp, "R1 probe during scan",
            {15'd0, host_ack, host_rdata}, {15'd0, 1'b1, probe_exp});
    end
    acc = dec_accept; mt = dec_match;
    rx_valid = 1'b0; host_req = 1'b0;
    @(negedge clk);
    chk(!dec_valid, "R9 strobe one cycle", 64'(dec_valid), 64'd0);
  endtask

  task automatic expect_frame(input logic [47:0] da, input bit acc_e, input logic [1:0] mt_e,
                              input string req, input int extra, input bit flip,
                              input bit probe, input logic [48:0] pexp);
    int lat; bit acc; logic [1:0] mt;
    frame(da, extra, flip, probe, pexp, lat, acc, mt);
    chk(lat == N + 2, "R9 latency", 64'(lat), 64'(N + 2));
    chk(acc == acc_e && mt == mt_e, req, {acc, mt}, {acc_e, mt_e});
  endtask

  localparam logic [47:0] A = 48'h0102_0304_0506;
  localparam logic [47:0] B = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] C = 48'h0A0B_0C0D_0E0F;
  localparam logic [47:0] D = 48'h1111_2222_3333;
  localparam logic [47:0] E = 48'h0100_5E00_0001;

  task automatic t_reset();
    chk(!dec_valid && !dec_accept && !host_ack, "R11 reset outputs",
        {dec_valid, dec_accept, host_ack}, 0);
  endtask

  task automatic t_host_rw();
    bit ak; logic [48:0] rd;
    wr(7'd5, {1'b1, D});
    host_op(1'b0, 7'd5, '0, ak, rd);
    chk(ak && rd == {1'b1, D}, "R1 slot 5 readback", {15'd0, ak, rd}, {15'd0, 1'b1, 1'b1, D});
    wr(7'd5, '0);
    host_op(1'b0, 7'd5, '0, ak, rd);
    chk(ak && rd == '0, "R1 slot 5 cleared", {15'd0, ak, rd}, {16'd1, 48'd0});
  endtask

  task automatic t_illegal();
    bit ak; logic [48:0] rd;
    host_op(1'b0, 7'd64, '0, ak, rd);  chk(!ak, "R2 addr 64 exact mode", 64'(ak), 0);
    host_op(1'b1, 7'd70, '1, ak, rd);  chk(!ak, "R2 addr 70", 64'(ak), 0);
    host_op(1'b0, 7'd127, '0, ak, rd); chk(!ak, "R2 addr 127", 64'(ak), 0);
    cfg_hash_mode = 1'b1;
    host_op(1'b0, 7'd62, '0, ak, rd);  chk(!ak, "R2 addr 62 hash mode", 64'(ak), 0);
    host_op(1'b0, 7'd63, '0, ak, rd);  chk(!ak, "R2 addr 63 hash mode", 64'(ak), 0);
    host_op(1'b0, 7'd64, '0, ak, rd);  chk(ak, "R6 addr 64 hash mode acked", 64'(ak), 1);
    cfg_hash_mode = 1'b0;
  endtask

  task automatic t_exact();
    wr(7'd0, {1'b1, A});
    wr(7'd63, {1'b1, B});
    expect_frame(A, 1'b1, 2'd1, "R3 exact hit slot 0", 12, 1'b0, 1'b0, '0);
    expect_frame(B, 1'b1, 2'd1, "R3 exact hit slot 63", 0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_invalid_and_miss();
    wr(7'd7, {1'b0, C});
    expect_frame(C, 1'b0, 2'd0, "R4 invalid slot ignored", 0, 1'b0, 1'b0, '0);
    expect_frame(D, 1'b0, 2'd0, "R8 no match", 3, 1'b0, 1'b0, '0);
  endtask

  task automatic t_hash();
    logic [5:0] ie, ib, id;
    logic [63:0] mask;
    ie = hidx(E); ib = hidx(B); id = hidx(D);
    mask = 64'd1 << ie;
    cfg_hash_mode = 1'b1;
    wr(7'd64, {17'd0, mask[31:0]});
    wr(7'd65, {17'd0, mask[63:32]});
    expect_frame(E, 1'b1, 2'd2, "R5 hash hit", 0, 1'b0, 1'b0, '0);
    expect_frame(D, (id == ie), (id == ie) ? 2'd2 : 2'd0, "R5 hash miss", 0, 1'b0, 1'b0, '0);
    // slot 63 now holds mask high half: B no longer an exact entry
    expect_frame(B, (ib == ie), (ib == ie) ? 2'd2 : 2'd0, "R6 slot 63 repurposed", 0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_prec();
    wr(7'd1, {1'b1, E});
    expect_frame(E, 1'b1, 2'd1, "R7 exact over hash", 0, 1'b0, 1'b0, '0);
    wr(7'd1, '0);
  endtask

  task automatic t_mode_latch();
    cfg_hash_mode = 1'b0;
    // frame starts in exact mode; slots 62/63 hold mask words with bit 48 clear
    expect_frame(E, 1'b0, 2'd0, "R10 mode held from SOF", 0, 1'b1, 1'b0, '0);
    chk(cfg_hash_mode == 1'b1, "R10 flip applied", 64'(cfg_hash_mode), 1);
  endtask

  task automatic t_overlap();
    cfg_hash_mode = 1'b1;
    expect_frame(E, 1'b1, 2'd2, "R5 hash hit with host reads", 0, 1'b0, 1'b1, {1'b1, A});
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    for (int i = 0; i < N; i++) wr(7'(i), '0);
    t_host_rw();
    t_illegal();
    t_exact();
    t_invalid_and_miss();
    t_hash();
    t_prec();
    t_mode_latch();
    t_overlap();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule